// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block holds a bank of 32-bit event counters for an Ethernet port. Each counter has its own event input. The MAC pulses that input for one cycle per event, and the counter adds one on that clock edge. A counter that passes its maximum value wraps to zero and sets a sticky overflow flag. The flags live in two carry registers: counters 0 to 31 use the low register and the remaining counters use the high register.

A host reaches every counter, both carry registers and a small control register through one synchronous port. The port has a request, a write enable, an address and write data, and returns read data one cycle after the request. The control register holds three bits:
- a global enable that freezes every counter when it is low;
- a clear-on-read mode that zeroes a counter right after the host reads it;
- a bulk-clear bit that wipes all counters and both carry registers, then drops back to zero on its own.

Top module: `stat_counter_bank`

## Requirements
- R1: While the enable bit (control bit 0) is 1, a counter whose event input is high on a clock edge increases by exactly one on that edge.
- R2: While the enable bit is 0, event inputs change no counter.
- R3: A counter at 0xFFFFFFFF that takes an event goes to 0 and sets its carry bit. Counter i maps to bit i of the low carry register for i < 32, and to bit i-32 of the high carry register otherwise.
- R4: A carry bit stays 1 until the host writes 1 to that bit or a bulk clear happens. Writing 0 to a bit has no effect, and a new overflow in the same cycle as its clearing write leaves the bit at 1.
- R5: Writing 1 to the bulk-clear bit (control bit 2) sets that bit for one cycle. On the following edge every counter and both carry registers become 0, events in that cycle are dropped, and the bit reads 0 again. Bits 0 and 1 keep their written values.
- R6: A host read returns, one cycle later, the addressed location's value as it was before the read's edge. The read data holds until the next read.
- R7: With clear-on-read (control bit 1) at 0, reading a counter leaves its value unchanged.
- R8: With clear-on-read at 1, the counter that was read is 0 after the read. If it also took an event in that cycle it ends at 1.
- R9: A host write to a counter loads the write data. An event to the same counter in that cycle is dropped.
- R10: After reset all counters, both carry registers, the control register and the read data are 0.
- R11: The address map is: counters at addresses 0 to N_CNT-1, control at 2^(ADDR_W-1), low carry at the next address, high carry at the one after. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_CNT | One event pulse per counter |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |

## Verification
Counter, carry and control state change on the edge that samples the event or access, so their effects are visible one cycle after the stimulus. Read data appears on the edge that takes the read and carries the value from before that edge. A bulk clear completes one edge after the control write that requests it. The bench drives each access on a falling edge and updates its model on the rising edge that consumes it. It compares the read data on the next falling edge, so each result is sampled exactly one edge after its stimulus.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_COR_BIT = 1;
  localparam int unsigned CTRL_CLR_BIT = 2;
  localparam logic [1:0]  SEL_CTRL     = 2'd0;
  localparam logic [1:0]  SEL_CAR_LO   = 2'd1;
  localparam logic [1:0]  SEL_CAR_HI   = 2'd2;
endpackage

// File: rtl/stat_cnt_cell.sv
module stat_cnt_cell #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bulk_clr_i,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] val_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, base;
  logic             inc;

  always_comb begin
    base   = rd_clr_i ? '0 : cnt_q;  // read-clear and event merge: ends at 1
    inc    = en_i & evt_i;
    wrap_o = inc & ~bulk_clr_i & ~wr_i & (&base);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (bulk_clr_i) cnt_q <= '0;
    else if (wr_i)       cnt_q <= wdata_i;
    else                 cnt_q <= base + {{(CNT_W-1){1'b0}}, inc};
  end

  assign val_o = cnt_q;
endmodule

// File: rtl/stat_carry_reg.sv
module stat_carry_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bulk_clr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (bulk_clr_i) q_o <= '0;
    else                 q_o <= (q_o & ~w1c_i) | set_i;  // set beats clear
  end
endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic       en_o,
  output logic       cor_o,
  output logic       clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      cor_o <= 1'b0;
      clr_o <= 1'b0;
    end else if (wr_i) begin
      en_o  <= wdata_i[stat_pkg::CTRL_EN_BIT];
      cor_o <= wdata_i[stat_pkg::CTRL_COR_BIT];
      clr_o <= wdata_i[stat_pkg::CTRL_CLR_BIT];
    end else begin
      clr_o <= 1'b0;  // self-clearing
    end
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter  int unsigned N_CNT  = 48,
  localparam int unsigned ADDR_W = $clog2(N_CNT) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CNT-1:0]           evt_i,
  input  logic                       host_req_i,
  input  logic                       host_we_i,
  input  logic [ADDR_W-1:0]          host_addr_i,
  input  logic [stat_pkg::DATA_W-1:0] host_wdata_i,
  output logic [stat_pkg::DATA_W-1:0] host_rdata_o
);
  import stat_pkg::*;

  localparam int unsigned LO_N  = DATA_W;
  localparam int unsigned HI_N  = N_CNT - LO_N;
  localparam int unsigned IDX_W = $clog2(N_CNT);

  logic              rd, wr, cnt_hit, reg_hit;
  logic [1:0]        reg_sel;
  logic              en_q, cor_q, clr_q;
  logic [N_CNT-1:0]  wrap;
  logic [LO_N-1:0]   car_lo, w1c_lo;
  logic [HI_N-1:0]   car_hi, w1c_hi;
  logic [DATA_W-1:0] cnt_val [N_CNT];
  logic [N_CNT*DATA_W-1:0] cnt_flat;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd      = host_req_i & ~host_we_i;
    wr      = host_req_i & host_we_i;
    cnt_hit = 32'(host_addr_i) < N_CNT;
    reg_hit = host_addr_i[ADDR_W-1] && (host_addr_i[ADDR_W-2:2] == '0);
    reg_sel = host_addr_i[1:0];
    w1c_lo  = (wr && reg_hit && reg_sel == SEL_CAR_LO) ? host_wdata_i[LO_N-1:0] : '0;
    w1c_hi  = (wr && reg_hit && reg_sel == SEL_CAR_HI) ? host_wdata_i[HI_N-1:0] : '0;
  end

  stat_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && reg_hit && reg_sel == SEL_CTRL),
    .wdata_i (host_wdata_i[2:0]),
    .en_o    (en_q),
    .cor_o   (cor_q),
    .clr_o   (clr_q)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    stat_cnt_cell #(.CNT_W(DATA_W)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bulk_clr_i (clr_q),
      .en_i       (en_q),
      .evt_i      (evt_i[i]),
      .wr_i       (wr && cnt_hit && host_addr_i == ADDR_W'(i)),
      .wdata_i    (host_wdata_i),
      .rd_clr_i   (rd && cnt_hit && cor_q && !clr_q && host_addr_i == ADDR_W'(i)),
      .val_o      (cnt_val[i]),
      .wrap_o     (wrap[i])
    );
    assign cnt_flat[i*DATA_W +: DATA_W] = cnt_val[i];
  end

  stat_carry_reg #(.W(LO_N)) u_car_lo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bulk_clr_i (clr_q),
    .set_i      (wrap[LO_N-1:0]),
    .w1c_i      (w1c_lo),
    .q_o        (car_lo)
  );

  stat_carry_reg #(.W(HI_N)) u_car_hi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bulk_clr_i (clr_q),
    .set_i      (wrap[N_CNT-1:LO_N]),
    .w1c_i      (w1c_hi),
    .q_o        (car_hi)
  );

  always_comb begin
    rd_mux = '0;
    if (cnt_hit) begin
      rd_mux = cnt_val[host_addr_i[IDX_W-1:0]];
    end else if (reg_hit) begin
      case (reg_sel)
        SEL_CTRL:   rd_mux = {{(DATA_W-3){1'b0}}, clr_q, cor_q, en_q};
        SEL_CAR_LO: rd_mux = car_lo;
        SEL_CAR_HI: rd_mux = DATA_W'(car_hi);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  host_rdata_o <= '0;
    else if (rd)  host_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk #(
  parameter int unsigned N_CNT  = 48,
  parameter int unsigned ADDR_W = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    host_req_i,
  input logic                    host_we_i,
  input logic [ADDR_W-1:0]       host_addr_i,
  input logic [31:0]             host_rdata_o,
  input logic [N_CNT*32-1:0]     cnt_flat,
  input logic [31:0]             car_lo,
  input logic [N_CNT-33:0]       car_hi,
  input logic                    en_q,
  input logic                    cor_q,
  input logic                    clr_q
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(1) << (ADDR_W-1);
  localparam logic [ADDR_W-1:0] CARLO_A = CTRL_A + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CARHI_A = CTRL_A + ADDR_W'(2);

  logic        is_cnt;
  logic [31:0] sel_val, idx_val;
  logic [ADDR_W-1:0] rd_idx_q;
  logic        rd_cor_q;

  always_comb begin
    is_cnt  = int'(host_addr_i) < int'(N_CNT);
    sel_val = is_cnt ? cnt_flat[int'(host_addr_i)*32 +: 32] : '0;
    idx_val = cnt_flat[int'(rd_idx_q)*32 +: 32];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      rd_cor_q <= 1'b0;
    end else begin
      rd_idx_q <= is_cnt ? host_addr_i : '0;
      rd_cor_q <= host_req_i && !host_we_i && is_cnt && cor_q && !clr_q;
    end
  end

  assert_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clr_q && !host_req_i) |=> $stable(cnt_flat));

  assert_sticky_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_q && !(host_req_i && host_we_i && host_addr_i == CARLO_A))
    |=> ((car_lo & $past(car_lo)) == $past(car_lo)));

  assert_sticky_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_q && !(host_req_i && host_we_i && host_addr_i == CARHI_A))
    |=> ((car_hi & $past(car_hi)) == $past(car_hi)));

  assert_bulk_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && !(host_req_i && host_we_i && host_addr_i == CTRL_A))
    |=> (cnt_flat == '0 && car_lo == '0 && car_hi == '0 && !clr_q));

  assert_read_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_we_i && is_cnt) |=> (host_rdata_o == $past(sel_val)));

  assert_clear_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cor_q |-> (idx_val <= 32'd1));
endmodule

bind stat_counter_bank stat_counter_bank_chk #(.N_CNT(N_CNT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_rdata_o (host_rdata_o),
  .cnt_flat     (cnt_flat),
  .car_lo       (car_lo),
  .car_hi       (car_hi),
  .en_q         (en_q),
  .cor_q        (cor_q),
  .clr_q        (clr_q)
);

// File: tb/tb_stat_counter_bank.sv
module tb_stat_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 48;
  localparam int AW = 7;
  localparam logic [AW-1:0] A_CTRL = 7'd64, A_LO = 7'd65, A_HI = 7'd66;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          host_req_i = 1'b0, host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [31:0]   host_wdata_i = '0;
  logic [31:0]   host_rdata_o;

  stat_counter_bank #(.N_CNT(N)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_cnt [N];
  logic [31:0] m_lo = '0;
  logic [15:0] m_hi = '0;
  logic m_en = 0, m_cor = 0, m_clr = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    if (int'(a) < N) return m_cnt[a];
    if (a == A_CTRL) return {29'd0, m_clr, m_cor, m_en};
    if (a == A_LO)   return m_lo;
    if (a == A_HI)   return {16'd0, m_hi};
    return '0;
  endfunction

  task automatic m_update(input bit rq, input bit we, input logic [AW-1:0] a,
                          input logic [31:0] wd, input logic [N-1:0] ev);
    logic [N-1:0] wrap = '0;
    if (m_clr) begin
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
      m_lo = '0; m_hi = '0; m_clr = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rq && we && int'(a) == i) m_cnt[i] = wd;
        else begin
          logic [31:0] b;
          b = (rq && !we && int'(a) == i && m_cor) ? 32'd0 : m_cnt[i];
          if (m_en && ev[i]) begin
            if (b == 32'hFFFF_FFFF) wrap[i] = 1'b1;
            b = b + 32'd1;
          end
          m_cnt[i] = b;
        end
      end
      if (rq && we && a == A_LO) m_lo = m_lo & ~wd;
      if (rq && we && a == A_HI) m_hi = m_hi & ~wd[15:0];
      m_lo = m_lo | wrap[31:0];
      m_hi = m_hi | wrap[47:32];
    end
    if (rq && we && a == A_CTRL) {m_clr, m_cor, m_en} = wd[2:0];
  endtask

  // starts and ends on a falling edge
  task automatic step(input bit rq, input bit we, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [N-1:0] ev, input string tag);
    logic [31:0] exp;
    host_req_i = rq; host_we_i = we; host_addr_i = a; host_wdata_i = wd; evt_i = ev;
    exp = m_read(a);
    @(posedge clk_i);
    m_update(rq, we, a, wd, ev);
    @(negedge clk_i);
    host_req_i = 0; host_we_i = 0; evt_i = '0;
    if (rq && !we) chk(tag, host_rdata_o, exp);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, a, '0, '0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    step(1, 1, a, d, '0, "");
  endtask
  task automatic idle(input logic [N-1:0] ev);
    step(0, 0, '0, '0, ev, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) m_cnt[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 rdata in reset", host_rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(7'd0, "R10 counter 0");
    rd(7'd47, "R10 counter 47");
    rd(A_CTRL, "R10 control");
    rd(A_LO, "R10 carry lo");
    rd(A_HI, "R10 carry hi");

    repeat (3) idle('1);
    rd(7'd5, "R2 frozen");
    chk("R2 frozen value", host_rdata_o, 32'd0);

    wr(A_CTRL, 32'd1);
    repeat (4) idle(48'd1 << 3);
    rd(7'd3, "R1 four events");
    chk("R1 count", host_rdata_o, 32'd4);
    rd(A_CTRL, "R11 control readback");
    rd(7'd3, "R7 reread");
    rd(7'd3, "R7 reread again");
    chk("R7 kept", host_rdata_o, 32'd4);

    step(1, 1, 7'd10, 32'd100, 48'd1 << 10, "");
    rd(7'd10, "R9 write beats event");
    chk("R9 value", host_rdata_o, 32'd100);

    wr(7'd40, 32'hFFFF_FFFF);
    idle(48'd1 << 40);
    rd(7'd40, "R3 wrap to zero");
    rd(A_HI, "R3 hi carry bit 8");
    chk("R3 hi bit", host_rdata_o, 32'h100);
    wr(7'd7, 32'hFFFF_FFFF);
    idle(48'd1 << 7);
    rd(A_LO, "R3 lo carry bit 7");
    chk("R3 lo bit", host_rdata_o, 32'h80);

    repeat (2) idle(48'd1 << 40);
    rd(A_HI, "R4 sticky hi");
    wr(A_LO, 32'd0);
    rd(A_LO, "R4 write zero no effect");
    wr(A_LO, 32'h80);
    rd(A_LO, "R4 write one clears");
    chk("R4 cleared", host_rdata_o, 32'd0);
    wr(7'd7, 32'hFFFF_FFFF);
    step(1, 1, A_LO, 32'h80, 48'd1 << 7, "");
    rd(A_LO, "R4 set beats clear");
    chk("R4 kept", host_rdata_o, 32'h80);

    wr(A_CTRL, 32'd3);
    rd(7'd3, "R8 read before clear");
    rd(7'd3, "R8 cleared by read");
    chk("R8 zero", host_rdata_o, 32'd0);
    repeat (2) idle(48'd1 << 3);
    step(1, 0, 7'd3, '0, 48'd1 << 3, "R6 pre-clear value with event");
    rd(7'd3, "R8 event kept");
    chk("R8 ends at one", host_rdata_o, 32'd1);

    rd(7'd50, "R11 unmapped counter space");
    rd(7'd67, "R11 unmapped register space");
    rd(7'd100, "R11 unmapped high");

    repeat (3) idle('1);
    wr(A_CTRL, 32'd7);
    step(1, 0, A_CTRL, '0, '1, "R5 clear bit visible");
    rd(A_CTRL, "R5 bit back to zero");
    chk("R5 control", host_rdata_o, 32'd3);
    rd(7'd0, "R5 counter 0 zero");
    rd(7'd47, "R5 counter 47 zero");
    rd(A_LO, "R5 lo zero");
    rd(A_HI, "R5 hi zero");

    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [N-1:0] ev;
      op = int'($urandom % 16);
      ev = {$urandom, $urandom} & {$urandom, $urandom};
      case (op)
        0, 1, 2, 3, 4, 5:
          step(1, 0, AW'($urandom % N), '0, ev, "R6 random read");
        6: step(1, 1, AW'($urandom % N),
                ($urandom % 2) ? 32'hFFFF_FFF0 | ($urandom % 16) : $urandom, ev, "");
        7: step(1, 0, ($urandom % 2) ? A_LO : A_HI, '0, ev, "R3 random carry read");
        8: step(1, 1, ($urandom % 2) ? A_LO : A_HI, $urandom, ev, "");
        9: step(1, 1, A_CTRL, ($urandom % 4 == 0) ? ($urandom % 8) : (1 | ($urandom % 4)),
                ev, "");
        10: step(1, 0, AW'(64 + $urandom % 64), '0, ev, "R11 random reg read");
        default: idle(ev);
      endcase
    end

    for (int i = 0; i < N; i++) rd(AW'(i), "R1 final sweep");
    rd(A_LO, "R4 final lo");
    rd(A_HI, "R4 final hi");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule